// File: doc/BRIEF.md
# Multiply-Subtract Product Shift Unit

This block is the execution datapath of one DSP-style instruction. In a single clocked step it does two things. It takes the previous product register value as an unsigned number and subtracts it from a 32-bit accumulator. It also multiplies a signed 32-bit multiplicand register by a signed 32-bit memory operand. The product is cut to its low 38 bits. A 32-bit window of that truncated product, picked by a shift-mode setting, becomes the new product register value.

The surrounding pipeline supplies the current register and flag state together with the operands and a valid strobe. The block returns the updated accumulator, product register, zero, negative, carry and overflow flags, and a 6-bit borrow counter. All of its outputs are registered. Operand address generation, fetch, decode and saturation are handled elsewhere.

Top module: `mac_msub_unit`

## Requirements
- R1: On a valid cycle, acc_o becomes (acc_i - p_i) mod 2^32. p_i is used as an unsigned value with no shift, whatever shift_code_i and shift_p4_i are.
- R2: With shift_p4_i low, p_o takes a window of t, where t is the low 38 bits of the product. Code 000 gives {t[30:0],0}. Code 001 gives t[31:0]. Codes 010 to 111 give t[31+k:k], with k = code - 1 (1 to 6), so code 111 gives t[37:6].
- R3: With shift_p4_i high, p_o = {t[27:0],4'b0000}, whatever shift_code_i is.
- R4: The product is signed xt_i times signed mem_i. Negative operands give the two's-complement low bits of the true product.
- R5: After a valid cycle, z_o is 1 exactly when acc_o is zero, and n_o equals acc_o[31].
- R6: c_o is 0 when the unsigned subtraction borrows (acc_i < p_i) and 1 otherwise.
- R7: v_o is 1 on signed overflow, meaning acc_i[31] differs from p_i[31] and the result's bit 31 differs from acc_i[31]. Otherwise v_o equals v_i.
- R8: ovc_o equals ovc_i - 1 modulo 64 when the subtraction borrows (so 0 wraps to 63), and equals ovc_i otherwise.
- R9: The results appear on the outputs one clock edge after a valid cycle. While valid_i is low, every output holds its value and all other inputs are ignored.
- R10: While rst_ni is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Execute strobe |
| xt_i | input | 32 | Multiplicand register value (signed) |
| mem_i | input | 32 | Memory operand (signed) |
| acc_i | input | 32 | Current accumulator |
| p_i | input | 32 | Current product register (unsigned) |
| v_i | input | 1 | Current overflow flag |
| ovc_i | input | 6 | Current borrow counter |
| shift_code_i | input | 3 | Product shift mode code |
| shift_p4_i | input | 1 | Selects left shift by 4, overriding the code |
| acc_o | output | 32 | Updated accumulator |
| p_o | output | 32 | Updated product register |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Negative flag |
| c_o | output | 1 | Carry (no-borrow) flag |
| v_o | output | 1 | Overflow flag |
| ovc_o | output | 6 | Updated borrow counter |

## Verification
The bench walks every shift code and the left-by-4 select over products with negative operands and with set bits above bit 37. A wrong window or a missing truncation shows up as a shifted or polluted p_o. It subtracts equal values, and a zero minus one with the counter at zero, to catch a reversed carry sense or a counter that saturates where it should wrap to 63. It drives signed overflow both ways and presents a set v_i with no overflow, which catches a flag that gets cleared when it should be kept. Idle cycles carry junk inputs, so an output that changes while the strobe is low is reported.

// File: rtl/msub_pkg.sv
package msub_pkg;
  localparam int DATA_W = 32;
  localparam int KEEP_W = 38;
  localparam int OVC_W  = 6;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    SHIFT_L1 = 3'b000,
    SHIFT_0  = 3'b001,
    SHIFT_R1 = 3'b010,
    SHIFT_R2 = 3'b011,
    SHIFT_R3 = 3'b100,
    SHIFT_R4 = 3'b101,
    SHIFT_R5 = 3'b110,
    SHIFT_R6 = 3'b111
  } shift_code_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/msub_mult.sv
module msub_mult #(
  parameter int DATA_W = msub_pkg::DATA_W,
  parameter int KEEP_W = msub_pkg::KEEP_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [KEEP_W-1:0] prod_o
);
  logic signed [KEEP_W-1:0] prod_s;

  // Product evaluated in KEEP_W context: operands sign-extend, upper bits never built
  always_comb prod_s = $signed(a_i) * $signed(b_i);
  assign prod_o = prod_s;
endmodule

// File: rtl/msub_window.sv
module msub_window #(
  parameter int DATA_W = msub_pkg::DATA_W,
  parameter int KEEP_W = msub_pkg::KEEP_W,
  parameter int CODE_W = msub_pkg::CODE_W
) (
  input  logic [KEEP_W-1:0] prod_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              p4_i,
  output logic [DATA_W-1:0] win_o
);
  localparam int N_CODES = 1 << CODE_W;

  logic [DATA_W-1:0] cand [N_CODES];
  logic [DATA_W-1:0] cand_p4;

  for (genvar g = 0; g < N_CODES; g++) begin : g_cand
    if (g == 0) begin : g_left1
      assign cand[g] = {prod_i[DATA_W-2:0], 1'b0};
    end else begin : g_right
      assign cand[g] = prod_i[(g-1) +: DATA_W];
    end
  end

  assign cand_p4 = {prod_i[DATA_W-5:0], 4'b0000};
  assign win_o   = p4_i ? cand_p4 : cand[code_i];
endmodule

// File: rtl/msub_sub_flags.sv
module msub_sub_flags
  import msub_pkg::*;
#(
  parameter int DATA_W = msub_pkg::DATA_W,
  parameter int OVC_W  = msub_pkg::OVC_W
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] p_i,
  input  logic              v_i,
  input  logic [OVC_W-1:0]  ovc_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flags_o,
  output logic [OVC_W-1:0]  ovc_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] diff;
  logic            borrow;
  logic            ovf;

  always_comb begin
    diff   = {1'b0, acc_i} - {1'b0, p_i};
    borrow = diff[DATA_W];
    res_o  = diff[DATA_W-1:0];
    ovf    = (acc_i[MSB] ^ p_i[MSB]) & (res_o[MSB] ^ acc_i[MSB]);
    flags_o.z = (res_o == '0);
    flags_o.n = res_o[MSB];
    flags_o.c = ~borrow;
    flags_o.v = ovf | v_i;
    ovc_o = borrow ? ovc_i - OVC_W'(1) : ovc_i;
  end
endmodule

// File: rtl/mac_msub_unit.sv
module mac_msub_unit
  import msub_pkg::*;
#(
  parameter int DATA_W = msub_pkg::DATA_W,
  parameter int KEEP_W = msub_pkg::KEEP_W,
  parameter int OVC_W  = msub_pkg::OVC_W,
  parameter int CODE_W = msub_pkg::CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] xt_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] p_i,
  input  logic              v_i,
  input  logic [OVC_W-1:0]  ovc_i,
  input  logic [CODE_W-1:0] shift_code_i,
  input  logic              shift_p4_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] p_o,
  output logic              z_o,
  output logic              n_o,
  output logic              c_o,
  output logic              v_o,
  output logic [OVC_W-1:0]  ovc_o
);
  logic [KEEP_W-1:0] prod;
  logic [DATA_W-1:0] win;
  logic [DATA_W-1:0] res;
  flags_t            flg_d, flg_q;
  logic [OVC_W-1:0]  ovc_d;

  msub_mult #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_mult (
    .a_i(xt_i), .b_i(mem_i), .prod_o(prod)
  );

  msub_window #(.DATA_W(DATA_W), .KEEP_W(KEEP_W), .CODE_W(CODE_W)) u_win (
    .prod_i(prod), .code_i(shift_code_i), .p4_i(shift_p4_i), .win_o(win)
  );

  msub_sub_flags #(.DATA_W(DATA_W), .OVC_W(OVC_W)) u_sub (
    .acc_i(acc_i), .p_i(p_i), .v_i(v_i), .ovc_i(ovc_i),
    .res_o(res), .flags_o(flg_d), .ovc_o(ovc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o <= '0;
      p_o   <= '0;
      flg_q <= '0;
      ovc_o <= '0;
    end else if (valid_i) begin
      acc_o <= res;
      p_o   <= win;
      flg_q <= flg_d;
      ovc_o <= ovc_d;
    end
  end

  assign z_o = flg_q.z;
  assign n_o = flg_q.n;
  assign c_o = flg_q.c;
  assign v_o = flg_q.v;
endmodule

// File: rtl/msub_checker.sv
module msub_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [31:0] acc_i,
  input logic [31:0] p_i,
  input logic        v_i,
  input logic [5:0]  ovc_i,
  input logic [2:0]  shift_code_i,
  input logic        shift_p4_i,
  input logic [31:0] acc_o,
  input logic [31:0] p_o,
  input logic        z_o,
  input logic        n_o,
  input logic        c_o,
  input logic        v_o,
  input logic [5:0]  ovc_o
);
  AST_ACC_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> acc_o == $past(acc_i) - $past(p_i)); // R1
  AST_LEFT1_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !shift_p4_i && shift_code_i == 3'b000 |=> p_o[0] == 1'b0); // R2
  AST_P4_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && shift_p4_i |=> p_o[3:0] == 4'b0000); // R3
  AST_ZERO_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (z_o == (acc_o == 32'd0)) && (n_o == acc_o[31])); // R5
  AST_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> c_o == ($past(acc_i) >= $past(p_i))); // R6
  AST_V_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (acc_i[31] == p_i[31]) |=> v_o == $past(v_i)); // R7
  AST_OVC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ovc_o == (($past(acc_i) < $past(p_i)) ? $past(ovc_i) - 6'd1 : $past(ovc_i))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable({acc_o, p_o, z_o, n_o, c_o, v_o, ovc_o})); // R9
  always_comb begin
    if (!rst_ni) begin
      AST_RESET_CLEAR: assert ({acc_o, p_o, z_o, n_o, c_o, v_o, ovc_o} == '0); // R10
    end
  end
endmodule

bind mac_msub_unit msub_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
  .acc_i(acc_i), .p_i(p_i), .v_i(v_i), .ovc_i(ovc_i),
  .shift_code_i(shift_code_i), .shift_p4_i(shift_p4_i),
  .acc_o(acc_o), .p_o(p_o), .z_o(z_o), .n_o(n_o),
  .c_o(c_o), .v_o(v_o), .ovc_o(ovc_o)
);

// File: tb/tb_mac_msub_unit.sv
`timescale 1ns/1ps
module tb_mac_msub_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] xt_i = '0, mem_i = '0, acc_i = '0, p_i = '0;
  logic        v_i = 1'b0;
  logic [5:0]  ovc_i = '0;
  logic [2:0]  shift_code_i = '0;
  logic        shift_p4_i = 1'b0;
  logic [31:0] acc_o, p_o;
  logic        z_o, n_o, c_o, v_o;
  logic [5:0]  ovc_o;

  always #2.5 clk_i = ~clk_i;

  mac_msub_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .xt_i(xt_i), .mem_i(mem_i), .acc_i(acc_i), .p_i(p_i),
    .v_i(v_i), .ovc_i(ovc_i), .shift_code_i(shift_code_i), .shift_p4_i(shift_p4_i),
    .acc_o(acc_o), .p_o(p_o), .z_o(z_o), .n_o(n_o),
    .c_o(c_o), .v_o(v_o), .ovc_o(ovc_o)
  );

  typedef struct {
    logic [31:0] acc;
    logic [31:0] p;
    logic        z, n, c, v;
    logic [5:0]  ovc;
    string       ptag;
  } exp_t;

  exp_t q[$];
  exp_t last;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   mon_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic exp_t model(input logic [31:0] xt, mem, acc, p, input logic v,
                                 input logic [5:0] ovc, input logic [2:0] code, input logic p4);
    exp_t e;
    longint prod;
    logic [63:0] pv;
    logic [37:0] t;
    logic [31:0] res;
    logic borrow, ovf;
    prod = longint'($signed(xt)) * longint'($signed(mem));
    pv = prod;
    t = pv[37:0];
    if (p4) e.p = {t[27:0], 4'h0};
    else if (code == 3'd0) e.p = {t[30:0], 1'b0};
    else e.p = 32'(t >> (code - 3'd1));
    res = acc - p;
    borrow = (acc < p);
    ovf = (acc[31] != p[31]) && (res[31] != acc[31]);
    e.acc = res;
    e.z = (res == 32'd0);
    e.n = res[31];
    e.c = !borrow;
    e.v = ovf ? 1'b1 : v;
    e.ovc = borrow ? ovc - 6'd1 : ovc;
    e.ptag = p4 ? "R3" : ((xt[31] | mem[31]) ? "R4" : "R2");
    return e;
  endfunction

  task automatic issue(input logic [31:0] xt, mem, acc, p, input logic v,
                       input logic [5:0] ovc, input logic [2:0] code, input logic p4);
    @(negedge clk_i);
    xt_i = xt; mem_i = mem; acc_i = acc; p_i = p; v_i = v; ovc_i = ovc;
    shift_code_i = code; shift_p4_i = p4; valid_i = 1'b1;
    q.push_back(model(xt, mem, acc, p, v, ovc, code, p4));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      xt_i = $urandom; mem_i = $urandom; acc_i = $urandom; p_i = $urandom;
      v_i = 1'($urandom); ovc_i = 6'($urandom);
      shift_code_i = 3'($urandom); shift_p4_i = 1'($urandom);
    end
  endtask

  task automatic cmp_all(input exp_t e, input bit hold);
    chk(acc_o == e.acc, hold ? "R9" : "R1", acc_o, e.acc);
    chk(p_o == e.p, hold ? "R9" : e.ptag, p_o, e.p);
    chk({z_o, n_o} == {e.z, e.n}, hold ? "R9" : "R5", {30'd0, z_o, n_o}, {30'd0, e.z, e.n});
    chk(c_o == e.c, hold ? "R9" : "R6", {31'd0, c_o}, {31'd0, e.c});
    chk(v_o == e.v, hold ? "R9" : "R7", {31'd0, v_o}, {31'd0, e.v});
    chk(ovc_o == e.ovc, hold ? "R9" : "R8", {26'd0, ovc_o}, {26'd0, e.ovc});
  endtask

  // monitor: sample 1 ns after each rising edge
  initial begin
    bit seen;
    last = '{acc: 0, p: 0, z: 0, n: 0, c: 0, v: 0, ovc: 0, ptag: "R9"};
    forever begin
      @(posedge clk_i);
      seen = valid_i;
      #1;
      if (mon_on) begin
        if (seen) begin
          if (q.size() == 0) chk(1'b0, "R9", 32'd0, 32'd1);
          else begin
            last = q.pop_front();
            cmp_all(last, 1'b0);
          end
        end else begin
          cmp_all(last, 1'b1);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] big_a, big_b;
    #7;
    // R10: outputs cleared in reset
    chk({acc_o, p_o} == 64'd0, "R10", acc_o | p_o, 32'd0);
    chk({z_o, n_o, c_o, v_o, ovc_o} == 10'd0, "R10", {22'd0, z_o, n_o, c_o, v_o, ovc_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    mon_on = 1'b1;
    idle(2);
    // every shift code, plus p4, on a product with bits above 37 (R2, R3, R4)
    big_a = 32'h7654_3210;
    big_b = 32'h0fed_cba9;
    for (int c = 0; c < 8; c++) begin
      issue(big_a, big_b, 32'd100, 32'd40, 1'b0, 6'd5, 3'(c), 1'b0);
      issue(32'hfedc_ba98, big_b, 32'd100, 32'd40, 1'b0, 6'd5, 3'(c), 1'b0);
    end
    issue(big_a, big_b, 32'd1, 32'd1, 1'b0, 6'd0, 3'd5, 1'b1);
    issue(32'hffff_fffd, 32'h0000_0007, 32'd1, 32'd1, 1'b0, 6'd0, 3'd1, 1'b0);
    issue(32'h8000_0000, 32'h8000_0000, 32'd1, 32'd1, 1'b0, 6'd0, 3'd7, 1'b0);
    idle(3);
    // equal values: zero, carry set, counter kept (R5 R6 R8)
    issue(32'd3, 32'd3, 32'h1234_5678, 32'h1234_5678, 1'b0, 6'd9, 3'd1, 1'b0);
    // 0 - 1 with counter at 0: wrap to 63, negative, borrow (R8 R6 R5)
    issue(32'd3, 32'd3, 32'd0, 32'd1, 1'b0, 6'd0, 3'd1, 1'b0);
    // signed overflow negative - positive (R7)
    issue(32'd1, 32'd1, 32'h8000_0000, 32'd1, 1'b0, 6'd2, 3'd1, 1'b0);
    // signed overflow positive - negative (R7)
    issue(32'd1, 32'd1, 32'h7fff_ffff, 32'hffff_ffff, 1'b0, 6'd2, 3'd1, 1'b0);
    // no overflow, v_i kept set (R7)
    issue(32'd1, 32'd1, 32'd10, 32'd3, 1'b1, 6'd2, 3'd1, 1'b0);
    // p unshifted regardless of mode (R1)
    issue(32'd1, 32'd1, 32'd1000, 32'd8, 1'b0, 6'd2, 3'd7, 1'b1);
    idle(4);
    // random traffic with random idle gaps
    for (int i = 0; i < 300; i++) begin
      issue($urandom, $urandom, $urandom, $urandom, 1'($urandom), 6'($urandom),
            3'($urandom), ($urandom % 4) == 0);
      if (($urandom % 3) == 0) idle(1 + ($urandom % 2));
    end
    idle(3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule